// File: doc/BRIEF.md
# Configuration Transaction Error Handler

This block sits beside the master side of a bus bridge. It watches each outbound configuration transaction on the expansion bus and decides how that transaction is completed toward the internal bus. A read that fails on the far side is returned inside the bridge as an aborted completion. The failure can be a master abort, a target abort or an uncorrectable data error. A write completes normally. Any data error on a write is reported later through a split completion error message. The block decodes that message and recognises two class/index encodings that both mean "write data was corrupted". One encoding comes from the completer and the other from an intermediate bridge.

Each failure kind has its own sticky status bit, and software clears a bit by writing a one to its position. The write-error bits only record while parity checking is enabled. The bits feed two interrupt sources. One is a split-completion error made from the two write-error bits. The other is a data-parity error made from the read data error bit. Each source has its own enable, and the combined interrupt leaves the block through a register.

Top module: `cfgerr_handler`

## Requirements
- R1: A read (`done_i`=1, `is_write_i`=0) with `mabort_i`=1 gives `cpl_vld_o`=1 and `cpl_abort_o`=1 in the cycle after the strobe, and sets status bit 0.
- R2: A read with `tabort_i`=1 gives an aborted completion in the cycle after the strobe and sets status bit 1.
- R3: A read with `uerr_i`=1 gives an aborted completion in the cycle after the strobe and sets status bit 2.
- R4: A read with no error flag, or any write (its abort and error flags are ignored), gives `cpl_vld_o`=1 and `cpl_abort_o`=0 in the cycle after the strobe and sets no status. `cpl_vld_o` is high for exactly one cycle per strobe.
- R5: With parity checking on, a message (`msg_vld_i`=1) of class 2h and index 01h sets status bit 3, the completer write error. Class 1h with index 02h sets status bit 4, the bridge write error. Both take effect at the next clock edge.
- R6: A message with any other class/index pair sets no status bit.
- R7: While `par_en_i`=0, messages set neither bit 3 nor bit 4.
- R8: Status bits are sticky. A bit clears only when `clr_vld_i`=1 with a one in the same position of `clr_bits_i`, and a set in the same cycle as a clear leaves the bit set.
- R9: `irq_o` equals, one cycle after the status it reflects, ((bit3 OR bit4) AND `irq_en_i[0]`) OR (bit2 AND `irq_en_i[1]`).
- R10: After reset all status bits, `cpl_vld_o`, `cpl_abort_o` and `irq_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_i | input | 1 | Configuration transaction finished on the expansion bus |
| is_write_i | input | 1 | 1 = write, 0 = read |
| mabort_i | input | 1 | Master abort seen |
| tabort_i | input | 1 | Target abort seen |
| uerr_i | input | 1 | Uncorrectable data error seen |
| par_en_i | input | 1 | Parity checking enabled |
| msg_vld_i | input | 1 | Split completion error message received |
| msg_class_i | input | CLASS_W | Message class |
| msg_index_i | input | INDEX_W | Message index |
| clr_vld_i | input | 1 | Write-one-to-clear strobe |
| clr_bits_i | input | 5 | Bits to clear |
| irq_en_i | input | 2 | [0] split-completion source enable, [1] data-parity source enable |
| cpl_vld_o | output | 1 | Internal completion valid |
| cpl_abort_o | output | 1 | Internal completion is aborted |
| status_o | output | 5 | Sticky status: [0] master abort, [1] target abort, [2] read data error, [3] completer write error, [4] bridge write error |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 4-bit class, an 8-bit index, the two recognised pairs 2h/01h and 1h/02h, and the registered interrupt variant. With these widths the bench can present near-miss messages that share either the class or the index with a recognised pair, and an unrelated class. It can also check the interrupt latency of exactly one cycle. The parity enable is toggled around the message checks, and a set is made in the same cycle as a clear.

// File: rtl/cfgerr_pkg.sv
package cfgerr_pkg;
   localparam int ST_W     = 5;
   localparam int ST_MABT  = 0;
   localparam int ST_TABT  = 1;
   localparam int ST_RDERR = 2;
   localparam int ST_WCMPL = 3;
   localparam int ST_WBRG  = 4;

   localparam int SRC_W     = 2;
   localparam int SRC_SPLIT = 0;
   localparam int SRC_PAR   = 1;

   typedef logic [ST_W-1:0]  st_vec_t;
   typedef logic [SRC_W-1:0] src_vec_t;

   typedef struct packed {
      logic vld;
      logic abort;
   } cpl_t;
endpackage

// File: rtl/cfgerr_cpl.sv
module cfgerr_cpl
   import cfgerr_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    done_i,
   input  logic    is_write_i,
   input  logic    mabort_i,
   input  logic    tabort_i,
   input  logic    uerr_i,
   output cpl_t    cpl_o,
   output logic    set_mabt_o,
   output logic    set_tabt_o,
   output logic    set_rderr_o
);
   logic rd_done;
   cpl_t cpl_q;

   assign rd_done     = done_i & ~is_write_i;
   assign set_mabt_o  = rd_done & mabort_i;
   assign set_tabt_o  = rd_done & tabort_i;
   assign set_rderr_o = rd_done & uerr_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cpl_q <= '0;
      end else begin
         cpl_q.vld   <= done_i;
         cpl_q.abort <= set_mabt_o | set_tabt_o | set_rderr_o;
      end
   end

   assign cpl_o = cpl_q;

   AST_RD_MABT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !is_write_i && mabort_i) |=> (cpl_o.vld && cpl_o.abort)); // R1
   AST_RD_TABT: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !is_write_i && tabort_i) |=> (cpl_o.vld && cpl_o.abort)); // R2
   AST_RD_UERR: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && !is_write_i && uerr_i) |=> (cpl_o.vld && cpl_o.abort)); // R3
   AST_WR_OK: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && is_write_i) |=> (cpl_o.vld && !cpl_o.abort)); // R4
   AST_NO_SPURIOUS_CPL: assert property (@(posedge clk) disable iff (!rst_n)
      !done_i |=> !cpl_o.vld); // R4
endmodule

// File: rtl/cfgerr_msg_dec.sv
module cfgerr_msg_dec #(
   parameter int CLASS_W    = 4,
   parameter int INDEX_W    = 8,
   parameter int CMPL_CLASS = 2,
   parameter int CMPL_INDEX = 1,
   parameter int BRG_CLASS  = 1,
   parameter int BRG_INDEX  = 2
) (
   input  logic               msg_vld_i,
   input  logic [CLASS_W-1:0] msg_class_i,
   input  logic [INDEX_W-1:0] msg_index_i,
   input  logic               par_en_i,
   output logic               set_cmpl_o,
   output logic               set_brg_o
);
   localparam logic [CLASS_W-1:0] CMPL_C = CLASS_W'(CMPL_CLASS);
   localparam logic [INDEX_W-1:0] CMPL_I = INDEX_W'(CMPL_INDEX);
   localparam logic [CLASS_W-1:0] BRG_C  = CLASS_W'(BRG_CLASS);
   localparam logic [INDEX_W-1:0] BRG_I  = INDEX_W'(BRG_INDEX);

   if (CLASS_W < 2 || CLASS_W > 8) begin : g_bad_class_w
      $error("cfgerr_msg_dec: CLASS_W out of range");
   end
   if (INDEX_W < 2 || INDEX_W > 16) begin : g_bad_index_w
      $error("cfgerr_msg_dec: INDEX_W out of range");
   end
   if (CMPL_CLASS >= (1 << CLASS_W) || BRG_CLASS >= (1 << CLASS_W)) begin : g_bad_class
      $error("cfgerr_msg_dec: class code does not fit CLASS_W");
   end
   if (CMPL_INDEX >= (1 << INDEX_W) || BRG_INDEX >= (1 << INDEX_W)) begin : g_bad_index
      $error("cfgerr_msg_dec: index code does not fit INDEX_W");
   end
   if (CMPL_CLASS == BRG_CLASS && CMPL_INDEX == BRG_INDEX) begin : g_same_pair
      $error("cfgerr_msg_dec: the two recognised pairs must differ");
   end

   logic hit_cmpl, hit_brg, accept;

   assign accept     = msg_vld_i & par_en_i;
   assign hit_cmpl   = (msg_class_i == CMPL_C) && (msg_index_i == CMPL_I);
   assign hit_brg    = (msg_class_i == BRG_C)  && (msg_index_i == BRG_I);
   assign set_cmpl_o = accept & hit_cmpl;
   assign set_brg_o  = accept & hit_brg;

   always_comb begin
      AST_ONE_WRITE_KIND: assert (!(set_cmpl_o && set_brg_o)); // R5
   end
endmodule

// File: rtl/cfgerr_status.sv
module cfgerr_status #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic         clr_vld_i,
   input  logic [W-1:0] clr_bits_i,
   output logic [W-1:0] st_o
);
   if (W < 1) begin : g_bad_w
      $error("cfgerr_status: W must be positive");
   end

   logic [W-1:0] clr;
   assign clr = clr_bits_i & {W{clr_vld_i}};

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n)       q <= 1'b0;
         else if (set_i[i]) q <= 1'b1;
         else if (clr[i])  q <= 1'b0;
      end
      assign st_o[i] = q;

      AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (q && !clr[i]) |=> q); // R8
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q); // R8
      AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (!rst_n)
         (!q && !set_i[i]) |=> !q); // R6
   end
endmodule

// File: rtl/cfgerr_irq.sv
module cfgerr_irq
   import cfgerr_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  st_vec_t  st_i,
   input  src_vec_t en_i,
   output logic     irq_o
);
   src_vec_t src;
   logic     irq_d;

   assign src[SRC_SPLIT] = st_i[ST_WCMPL] | st_i[ST_WBRG];
   assign src[SRC_PAR]   = st_i[ST_RDERR];
   assign irq_d          = |(src & en_i);

   if (IRQ_REG) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= irq_d;
      end
      assign irq_o = irq_q;

      AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
         irq_d |=> irq_o); // R9
      AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         !irq_d |=> !irq_o); // R9
   end else begin : g_comb
      assign irq_o = irq_d;
   end
endmodule

// File: rtl/cfgerr_handler.sv
module cfgerr_handler
   import cfgerr_pkg::*;
#(
   parameter int CLASS_W    = 4,
   parameter int INDEX_W    = 8,
   parameter int CMPL_CLASS = 2,
   parameter int CMPL_INDEX = 1,
   parameter int BRG_CLASS  = 1,
   parameter int BRG_INDEX  = 2,
   parameter bit IRQ_REG    = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               done_i,
   input  logic               is_write_i,
   input  logic               mabort_i,
   input  logic               tabort_i,
   input  logic               uerr_i,
   input  logic               par_en_i,
   input  logic               msg_vld_i,
   input  logic [CLASS_W-1:0] msg_class_i,
   input  logic [INDEX_W-1:0] msg_index_i,
   input  logic               clr_vld_i,
   input  logic [4:0]         clr_bits_i,
   input  logic [1:0]         irq_en_i,
   output logic               cpl_vld_o,
   output logic               cpl_abort_o,
   output logic [4:0]         status_o,
   output logic               irq_o
);
   cpl_t    cpl;
   st_vec_t set_v, st;
   logic    set_mabt, set_tabt, set_rderr, set_cmpl, set_brg;

   cfgerr_cpl u_cpl (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (done_i),
      .is_write_i  (is_write_i),
      .mabort_i    (mabort_i),
      .tabort_i    (tabort_i),
      .uerr_i      (uerr_i),
      .cpl_o       (cpl),
      .set_mabt_o  (set_mabt),
      .set_tabt_o  (set_tabt),
      .set_rderr_o (set_rderr)
   );

   cfgerr_msg_dec #(
      .CLASS_W    (CLASS_W),
      .INDEX_W    (INDEX_W),
      .CMPL_CLASS (CMPL_CLASS),
      .CMPL_INDEX (CMPL_INDEX),
      .BRG_CLASS  (BRG_CLASS),
      .BRG_INDEX  (BRG_INDEX)
   ) u_dec (
      .msg_vld_i   (msg_vld_i),
      .msg_class_i (msg_class_i),
      .msg_index_i (msg_index_i),
      .par_en_i    (par_en_i),
      .set_cmpl_o  (set_cmpl),
      .set_brg_o   (set_brg)
   );

   always_comb begin
      set_v           = '0;
      set_v[ST_MABT]  = set_mabt;
      set_v[ST_TABT]  = set_tabt;
      set_v[ST_RDERR] = set_rderr;
      set_v[ST_WCMPL] = set_cmpl;
      set_v[ST_WBRG]  = set_brg;
   end

   cfgerr_status #(.W(ST_W)) u_st (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set_v),
      .clr_vld_i  (clr_vld_i),
      .clr_bits_i (clr_bits_i),
      .st_o       (st)
   );

   cfgerr_irq #(.IRQ_REG(IRQ_REG)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .st_i  (st),
      .en_i  (irq_en_i),
      .irq_o (irq_o)
   );

   assign cpl_vld_o   = cpl.vld;
   assign cpl_abort_o = cpl.abort;
   assign status_o    = st;

   AST_PAR_GATE_CMPL: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_en_i && !status_o[ST_WCMPL]) |=> !status_o[ST_WCMPL]); // R7
   AST_PAR_GATE_BRG: assert property (@(posedge clk) disable iff (!rst_n)
      (!par_en_i && !status_o[ST_WBRG]) |=> !status_o[ST_WBRG]); // R7
   AST_WR_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && is_write_i && !msg_vld_i && !clr_vld_i) |=> $stable(status_o)); // R4
endmodule

// File: tb/sim_cfgerr_handler.sv
`timescale 1ns/1ps
module sim_cfgerr_handler;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       done_i = 0, is_write_i = 0, mabort_i = 0, tabort_i = 0, uerr_i = 0;
   logic       par_en_i = 0, msg_vld_i = 0, clr_vld_i = 0;
   logic [3:0] msg_class_i = '0;
   logic [7:0] msg_index_i = '0;
   logic [4:0] clr_bits_i = '0;
   logic [1:0] irq_en_i = '0;
   logic       cpl_vld_o, cpl_abort_o, irq_o;
   logic [4:0] status_o;

   int   n_run = 0, n_fail = 0;
   bit   finished = 0;
   logic exp_q[$];
   logic [4:0] exp_st = '0;

   always #2.5 clk = ~clk;

   cfgerr_handler u0 (
      .clk(clk), .rst_n(rst_n), .done_i(done_i), .is_write_i(is_write_i),
      .mabort_i(mabort_i), .tabort_i(tabort_i), .uerr_i(uerr_i),
      .par_en_i(par_en_i), .msg_vld_i(msg_vld_i), .msg_class_i(msg_class_i),
      .msg_index_i(msg_index_i), .clr_vld_i(clr_vld_i), .clr_bits_i(clr_bits_i),
      .irq_en_i(irq_en_i), .cpl_vld_o(cpl_vld_o), .cpl_abort_o(cpl_abort_o),
      .status_o(status_o), .irq_o(irq_o)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // monitor: pops expected completions as the design produces them
   always @(negedge clk) begin
      if (rst_n && cpl_vld_o) begin
         if (exp_q.size() == 0) begin
            check(0, "R4 unexpected completion", 1, 0);
         end else begin
            logic e;
            e = exp_q.pop_front();
            check(cpl_abort_o == e, "R1/R2/R3/R4 completion abort", cpl_abort_o, e);
         end
      end
   end

   // driver: one transaction, pushes its expected completion
   task automatic txn(input bit wr, input bit ma, input bit ta, input bit ue);
      done_i = 1; is_write_i = wr; mabort_i = ma; tabort_i = ta; uerr_i = ue;
      exp_q.push_back(!wr && (ma || ta || ue));
      if (!wr) exp_st = exp_st | {2'b00, ue, ta, ma};
      @(negedge clk);
      done_i = 0; is_write_i = 0; mabort_i = 0; tabort_i = 0; uerr_i = 0;
   endtask

   task automatic msg(input logic [3:0] c, input logic [7:0] i);
      msg_vld_i = 1; msg_class_i = c; msg_index_i = i;
      if (par_en_i && c == 4'h2 && i == 8'h01) exp_st[3] = 1'b1;
      if (par_en_i && c == 4'h1 && i == 8'h02) exp_st[4] = 1'b1;
      @(negedge clk);
      msg_vld_i = 0;
   endtask

   task automatic clr(input logic [4:0] m);
      clr_vld_i = 1; clr_bits_i = m;
      exp_st = exp_st & ~m;
      @(negedge clk);
      clr_vld_i = 0; clr_bits_i = '0;
   endtask

   task automatic chk_st(input string tag);
      check(status_o == exp_st, tag, status_o, exp_st);
   endtask

   task automatic chk_irq(input string tag);
      logic e;
      @(negedge clk);
      e = ((exp_st[3] | exp_st[4]) & irq_en_i[0]) | (exp_st[2] & irq_en_i[1]);
      check(irq_o == e, tag, irq_o, e);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(status_o == 0, "R10 reset status", status_o, 0);
      check(cpl_vld_o == 0 && cpl_abort_o == 0, "R10 reset completion", {cpl_vld_o, cpl_abort_o}, 0);
      check(irq_o == 0, "R10 reset irq", irq_o, 0);
      rst_n = 1;
      @(negedge clk);

      txn(0, 0, 0, 0);  chk_st("R4 clean read no status");
      txn(0, 1, 0, 0);  chk_st("R1 master abort status");
      txn(0, 0, 1, 0);  chk_st("R2 target abort status");
      txn(0, 0, 0, 1);  chk_st("R3 read data error status");
      txn(1, 1, 1, 1);  chk_st("R4 write flags ignored");
      txn(1, 0, 0, 0);  txn(0, 0, 0, 0);
      chk_st("R4 back-to-back");
      @(negedge clk);
      check(cpl_vld_o == 0, "R4 completion one cycle", cpl_vld_o, 0);

      // R8: clear and same-cycle set
      clr(5'b00010);    chk_st("R8 clear target abort");
      done_i = 1; mabort_i = 1; clr_vld_i = 1; clr_bits_i = 5'b00001;
      exp_q.push_back(1'b1);
      @(negedge clk);
      done_i = 0; mabort_i = 0; clr_vld_i = 0; clr_bits_i = '0;
      chk_st("R8 set wins over clear");
      repeat (2) @(negedge clk);
      chk_st("R8 sticky hold");
      clr(5'b00101);    chk_st("R8 clear multiple");

      // R7: parity disabled
      par_en_i = 0;
      msg(4'h2, 8'h01); chk_st("R7 completer msg gated");
      msg(4'h1, 8'h02); chk_st("R7 bridge msg gated");

      // R5
      par_en_i = 1;
      msg(4'h2, 8'h01); chk_st("R5 completer write error");
      msg(4'h1, 8'h02); chk_st("R5 bridge write error");
      clr(5'b11000);    chk_st("R8 clear write errors");

      // R6 near misses
      msg(4'h2, 8'h02); chk_st("R6 class2 index02 ignored");
      msg(4'h1, 8'h01); chk_st("R6 class1 index01 ignored");
      msg(4'h3, 8'h01); chk_st("R6 class3 ignored");
      msg(4'h2, 8'hFF); chk_st("R6 index FF ignored");
      msg(4'h0, 8'h00); chk_st("R6 zero pair ignored");

      // R9 interrupt
      irq_en_i = 2'b00;
      msg(4'h2, 8'h01); chk_irq("R9 masked split source");
      irq_en_i = 2'b01; chk_irq("R9 unmasked split source");
      clr(5'b01000);    chk_irq("R9 irq drops after clear");
      txn(0, 0, 0, 1);  chk_irq("R9 parity source masked");
      irq_en_i = 2'b10; chk_irq("R9 parity source unmasked");
      irq_en_i = 2'b00; chk_irq("R9 mask again");
      // exact one-cycle latency
      irq_en_i = 2'b10;
      @(negedge clk);
      check(irq_o == 1, "R9 one cycle latency", irq_o, 1);

      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R4 all completions seen", exp_q.size(), 0);
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule